// File: doc/BRIEF.md
# Eight-Pin GPIO Port Controller with Commit-Guarded Pin Muxing

The block controls an 8-pin general-purpose I/O port through a simple synchronous register bus. Each pin is driven either by software, through an output latch and a direction bit, or by a peripheral that supplies its own value and enable. Per-pin configuration bits choose the source, open-drain behaviour, digital enable and pull resistors. The resulting pad output value, output enable and pull controls are driven straight to the pad ring.

A small set of reserved pins comes out of reset already handed to their peripheral with the digital path enabled. Their source-select bits are guarded. A 32-bit key must open a lock. A commit mask, itself writable only while the lock is open, must then name the bit before a write to it is kept. Input data passes a two-flop synchronizer before software or the peripheral sees it.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset: source-select and digital-enable read back the reserved mask (default 0x0F). Direction, open-drain, data latch and both pull registers are 0. The lock reads 1. Commit reads the complement of the reserved mask. No pull is driven.
- R2: With source-select 0 and digital enable 1, direction 1 drives the data latch on pad_out with pad_oe high, and direction 0 leaves pad_oe low.
- R3: With source-select 1, pad_out follows alt_out and pad_oe follows alt_oe. The direction bit has no effect.
- R4: With open-drain 1, pad_out is 0 and pad_oe is high only when the selected direction is 1 and the selected value is 0. This holds in both software and peripheral mode.
- R5: With digital enable 0, pad_oe and pad_out are 0. That pin's bit in a data read is 0, and its alt_in bit is 0.
- R6: A data read returns the latched output for pins with direction 1 and source-select 0. For all other enabled pins it returns pad_in delayed by two clock edges. alt_in is the same synchronized input, gated by digital enable.
- R7: Writing 0x4C4F434B to the lock address opens the lock, and writing any other value closes it. The lock reads 1 while closed and 0 while open.
- R8: A write to the commit register while the lock is closed leaves it unchanged.
- R9: A write to source-select stores a reserved bit only if the lock is open and that bit's commit bit is 1. Otherwise the old value is kept. Non-reserved bits always take the written value.
- R10: Writing 1 to a bit of the pull-up register clears that bit in the pull-down register, and the reverse. pad_pu and pad_pd mirror the two registers.
- R11: Word addresses are: 0 data, 1 direction, 2 source-select, 3 open-drain, 4 digital enable, 5 pull-up, 6 pull-down, 7 lock, 8 commit. Writes take bits 7:0, except the lock, which takes all 32 bits. Reads are combinational on bus_addr and zero-extended. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pull-up enable |
| pad_pd | output | 8 | Pull-down enable |
| alt_out | input | 8 | Peripheral output value per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| alt_in | output | 8 | Synchronized, enable-gated input to the peripheral |

## Verification
Two events can land in the same cycle: a register write that reconfigures a pin, and a change of pad_in, alt_out or alt_oe on that pin. The stimulus provokes this on every random iteration by changing all three external inputs on the same edge as a write to a random address. That address is sometimes the lock key. The bench waits out the two synchronizer edges, then compares every pad output, alt_in and every register read against a requirement-level model of the port.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 4;
    localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h4C4F_434B;

    typedef enum logic [BUS_AW-1:0] {
        RA_DATA   = 4'd0,
        RA_DIR    = 4'd1,
        RA_SRCSEL = 4'd2,
        RA_OPEND  = 4'd3,
        RA_DIGEN  = 4'd4,
        RA_PULLUP = 4'd5,
        RA_PULLDN = 4'd6,
        RA_LOCK   = 4'd7,
        RA_COMMIT = 4'd8
    } reg_addr_e;

    typedef struct packed {
        logic srcsel;
        logic dir;
        logic opend;
        logic digen;
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    // Resolve one pin: pick the source, then apply enable and open-drain shaping.
    function automatic pin_drv_t pad_drive(pin_cfg_t c, logic sw_val, logic pe_val, logic pe_oe);
        pin_drv_t r;
        logic     v;
        logic     d;
        v = c.srcsel ? pe_val : sw_val;
        d = c.srcsel ? pe_oe  : c.dir;
        if (!c.digen) begin
            r = '0;
        end else if (c.opend) begin
            r.oe  = d & ~v;
            r.val = 1'b0;
        end else begin
            r.oe  = d;
            r.val = v;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) st[g] <= '0;
                else if (g == 0) st[g] <= d;
                else st[g] <= st[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int unsigned     NPIN     = 8,
    parameter logic [NPIN-1:0] RSV_MASK = NPIN'(15)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [NPIN-1:0]   data_q,
    output logic [NPIN-1:0]   dir_q,
    output logic [NPIN-1:0]   srcsel_q,
    output logic [NPIN-1:0]   opend_q,
    output logic [NPIN-1:0]   digen_q,
    output logic [NPIN-1:0]   pu_q,
    output logic [NPIN-1:0]   pd_q,
    output logic [NPIN-1:0]   commit_q,
    output logic              unlocked_q
);
    logic [NPIN-1:0] wd;
    logic [NPIN-1:0] sel_wmask;
    logic [NPIN-1:0] sel_blocked;

    assign wd          = bus_wdata[NPIN-1:0];
    assign sel_wmask   = ~RSV_MASK | (commit_q & {NPIN{unlocked_q}});
    assign sel_blocked = ~sel_wmask;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q     <= '0;
            dir_q      <= '0;
            srcsel_q   <= RSV_MASK;
            opend_q    <= '0;
            digen_q    <= RSV_MASK;
            pu_q       <= '0;
            pd_q       <= '0;
            commit_q   <= ~RSV_MASK;
            unlocked_q <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                RA_DATA:   data_q   <= wd;
                RA_DIR:    dir_q    <= wd;
                RA_SRCSEL: srcsel_q <= (wd & sel_wmask) | (srcsel_q & sel_blocked);
                RA_OPEND:  opend_q  <= wd;
                RA_DIGEN:  digen_q  <= wd;
                RA_PULLUP: begin
                    pu_q <= wd;
                    pd_q <= pd_q & ~wd;
                end
                RA_PULLDN: begin
                    pd_q <= wd;
                    pu_q <= pu_q & ~wd;
                end
                RA_LOCK:   unlocked_q <= (bus_wdata == UNLOCK_KEY);
                RA_COMMIT: if (unlocked_q) commit_q <= wd;
                default: ;
            endcase
        end
    end

    assert_pull_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        (pu_q & pd_q) == '0);

    assert_guarded_sel_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((srcsel_q ^ $past(srcsel_q)) & $past(sel_blocked)) == '0);

    assert_relock_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_LOCK && bus_wdata != UNLOCK_KEY) |=> !unlocked_q);

    assert_commit_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == RA_COMMIT && !unlocked_q) |=> $stable(commit_q));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pkg::*;
#(
    parameter int unsigned NPIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] data_q,
    input  logic [NPIN-1:0] dir_q,
    input  logic [NPIN-1:0] srcsel_q,
    input  logic [NPIN-1:0] opend_q,
    input  logic [NPIN-1:0] digen_q,
    input  logic [NPIN-1:0] alt_out,
    input  logic [NPIN-1:0] alt_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe
);
    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            pin_cfg_t cfg;
            pin_drv_t drv;
            assign cfg = '{srcsel: srcsel_q[p], dir: dir_q[p], opend: opend_q[p], digen: digen_q[p]};
            assign drv = pad_drive(cfg, data_q[p], alt_out[p], alt_oe[p]);
            assign pad_out[p] = drv.val;
            assign pad_oe[p]  = drv.oe;
        end
    endgenerate

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_out) & ~digen_q) == '0);

    assert_opendrain_low_R4: assert property (@(posedge clk) disable iff (rst)
        (pad_out & opend_q) == '0);

    assert_peripheral_follow_R3: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe ^ alt_oe) & srcsel_q & digen_q & ~opend_q) == '0);
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_pkg::*;
#(
    parameter int unsigned     NPIN     = 8,
    parameter logic [NPIN-1:0] RSV_MASK = NPIN'(15)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pu,
    output logic [NPIN-1:0]   pad_pd,
    input  logic [NPIN-1:0]   alt_out,
    input  logic [NPIN-1:0]   alt_oe,
    output logic [NPIN-1:0]   alt_in
);
    localparam int unsigned SYNC_STAGES = 2;

    logic [NPIN-1:0] data_q, dir_q, srcsel_q, opend_q, digen_q, pu_q, pd_q, commit_q;
    logic            unlocked_q;
    logic [NPIN-1:0] in_sync;
    logic [NPIN-1:0] data_view;

    gpio_regfile #(.NPIN(NPIN), .RSV_MASK(RSV_MASK)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q), .srcsel_q(srcsel_q), .opend_q(opend_q),
        .digen_q(digen_q), .pu_q(pu_q), .pd_q(pd_q), .commit_q(commit_q),
        .unlocked_q(unlocked_q)
    );

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(in_sync)
    );

    gpio_pad_mux #(.NPIN(NPIN)) u_mux (
        .clk(clk), .rst(rst), .data_q(data_q), .dir_q(dir_q), .srcsel_q(srcsel_q),
        .opend_q(opend_q), .digen_q(digen_q), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign pad_pu    = pu_q;
    assign pad_pd    = pd_q;
    assign alt_in    = in_sync & digen_q;
    assign data_view = digen_q & ((dir_q & ~srcsel_q & data_q) | (~(dir_q & ~srcsel_q) & in_sync));

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_DATA:   bus_rdata[NPIN-1:0] = data_view;
            RA_DIR:    bus_rdata[NPIN-1:0] = dir_q;
            RA_SRCSEL: bus_rdata[NPIN-1:0] = srcsel_q;
            RA_OPEND:  bus_rdata[NPIN-1:0] = opend_q;
            RA_DIGEN:  bus_rdata[NPIN-1:0] = digen_q;
            RA_PULLUP: bus_rdata[NPIN-1:0] = pu_q;
            RA_PULLDN: bus_rdata[NPIN-1:0] = pd_q;
            RA_LOCK:   bus_rdata[0]        = ~unlocked_q;
            RA_COMMIT: bus_rdata[NPIN-1:0] = commit_q;
            default: ;
        endcase
    end

    assert_read_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == RA_DATA) |-> ((bus_rdata[NPIN-1:0] | alt_in) & ~digen_q) == '0);

    assert_sync_delay_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(digen_q) != digen_q) || (alt_in == ($past(in_sync_d1) & digen_q)));

    logic [NPIN-1:0] in_sync_d1;
    always_ff @(posedge clk) begin
        if (rst) in_sync_d1 <= '0;
        else     in_sync_d1 <= pad_in;
    end
endmodule

// File: tb/test_gpio_port_ctl.sv
module test_gpio_port_ctl;
    import gpio_pkg::*;

    localparam int unsigned NPIN = 8;
    localparam logic [7:0]  RSV  = 8'h0F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd;
    logic [7:0]  alt_out = '0, alt_oe = '0, alt_in;

    int checks = 0;
    int fails  = 0;

    // Requirement-level model of the port state
    logic [7:0] m_data, m_dir, m_sel, m_od, m_den, m_pu, m_pd, m_cr;
    logic       m_unl;

    gpio_port_ctl #(.NPIN(NPIN), .RSV_MASK(RSV)) i_gpio_port_ctl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_data = '0; m_dir = '0; m_sel = RSV; m_od = '0; m_den = RSV;
        m_pu = '0; m_pd = '0; m_cr = ~RSV; m_unl = 1'b0;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [31:0] w);
        logic [7:0] wb;
        logic [7:0] msk;
        wb  = w[7:0];
        msk = ~RSV | (m_unl ? m_cr : 8'h00);
        case (a)
            4'd0: m_data = wb;
            4'd1: m_dir  = wb;
            4'd2: m_sel  = (wb & msk) | (m_sel & ~msk);
            4'd3: m_od   = wb;
            4'd4: m_den  = wb;
            4'd5: begin m_pu = wb; m_pd = m_pd & ~wb; end
            4'd6: begin m_pd = wb; m_pu = m_pu & ~wb; end
            4'd7: m_unl = (w == 32'h4C4F434B);
            4'd8: if (m_unl) m_cr = wb;
            default: ;
        endcase
    endtask

    // Call at a falling edge; returns at the next falling edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] w);
        bus_addr = a; bus_wdata = w; bus_wr = 1'b1;
        model_write(a, w);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        logic [7:0] outpin;
        outpin = m_dir & ~m_sel;
        case (a)
            4'd0: return {24'h0, m_den & ((outpin & m_data) | (~outpin & pad_in))};
            4'd1: return {24'h0, m_dir};
            4'd2: return {24'h0, m_sel};
            4'd3: return {24'h0, m_od};
            4'd4: return {24'h0, m_den};
            4'd5: return {24'h0, m_pu};
            4'd6: return {24'h0, m_pd};
            4'd7: return {31'h0, ~m_unl};
            4'd8: return {24'h0, m_cr};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] exp_pad();
        logic [7:0] o, e;
        for (int i = 0; i < 8; i++) begin
            logic v, d;
            v = m_sel[i] ? alt_out[i] : m_data[i];
            d = m_sel[i] ? alt_oe[i]  : m_dir[i];
            if (!m_den[i])     begin o[i] = 1'b0; e[i] = 1'b0; end
            else if (m_od[i])  begin o[i] = 1'b0; e[i] = d & ~v; end
            else               begin o[i] = v;    e[i] = d; end
        end
        return {e, o};
    endfunction

    task automatic check_all();
        logic [31:0] v;
        chk("R2 R3 R4 R5 pad_out", {24'h0, pad_out}, {24'h0, exp_pad()[7:0]});
        chk("R2 R3 R4 R5 pad_oe",  {24'h0, pad_oe},  {24'h0, exp_pad()[15:8]});
        chk("R10 pulls", {16'h0, pad_pu, pad_pd}, {16'h0, m_pu, m_pd});
        chk("R6 alt_in", {24'h0, alt_in}, {24'h0, pad_in & m_den});
        for (int a = 0; a < 10; a++) begin
            rd(4'(a), v);
            chk("R11 readback", v, exp_read(4'(a)));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1357));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'd2, v); chk("R1 srcsel", v, 32'h0F);
        rd(4'd4, v); chk("R1 digen", v, 32'h0F);
        rd(4'd7, v); chk("R1 lock closed", v, 32'h1);
        rd(4'd8, v); chk("R1 commit", v, 32'hF0);
        chk("R1 pads", {8'h0, pad_oe, pad_pu, pad_pd}, 32'h0);
        check_all();

        // R9 guarded source-select while locked
        wr(4'd2, 32'h00); rd(4'd2, v); chk("R9 locked clear", v, 32'h0F);
        wr(4'd2, 32'hF0); rd(4'd2, v); chk("R9 free bits", v, 32'hFF);
        // R7 open the lock
        wr(4'd7, 32'h4C4F434B); rd(4'd7, v); chk("R7 open reads 0", v, 32'h0);
        wr(4'd8, 32'hF1); rd(4'd8, v); chk("R8 commit when open", v, 32'hF1);
        wr(4'd2, 32'h00); rd(4'd2, v); chk("R9 committed bit", v, 32'h0E);
        wr(4'd7, 32'h4C4F434A); rd(4'd7, v); chk("R7 wrong key relocks", v, 32'h1);
        wr(4'd8, 32'hFF); rd(4'd8, v); chk("R8 commit locked", v, 32'hF1);
        wr(4'd2, 32'h0F); rd(4'd2, v); chk("R9 relocked keeps", v, 32'h0E);

        // R6 two-edge synchronizer latency on pin 7, input mode
        wr(4'd4, 32'hFF); wr(4'd1, 32'h00);
        pad_in = 8'h80;
        @(negedge clk); rd(4'd0, v); chk("R6 one edge", {31'h0, v[7]}, 32'h0);
        @(negedge clk); rd(4'd0, v); chk("R6 two edges", {31'h0, v[7]}, 32'h1);
        wr(4'd1, 32'h80); wr(4'd0, 32'h00); rd(4'd0, v); chk("R6 output latch", {31'h0, v[7]}, 32'h0);
        chk("R2 drive low", {30'h0, pad_oe[7], pad_out[7]}, 32'h2);

        // R5 disabled pin reads 0
        wr(4'd1, 32'h00); wr(4'd4, 32'h7F); rd(4'd0, v);
        chk("R5 read gated", {31'h0, v[7]}, 32'h0);
        chk("R5 alt_in gated", {31'h0, alt_in[7]}, 32'h0);

        // R10 pull exclusivity
        wr(4'd5, 32'hFF); wr(4'd6, 32'h0F);
        chk("R10 exclusive", {16'h0, pad_pu, pad_pd}, 32'hF00F);

        // Random phase: inputs change in the same cycle as a random write
        for (int it = 0; it < 400; it++) begin
            logic [3:0]  a;
            logic [31:0] w;
            a = 4'($urandom_range(0, 9));
            w = $urandom();
            if (a == 4'd7 && $urandom_range(0, 1) == 0) w = 32'h4C4F434B;
            pad_in  = 8'($urandom());
            alt_out = 8'($urandom());
            alt_oe  = 8'($urandom());
            wr(a, w);
            @(negedge clk);
            check_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule